// File: doc/BRIEF.md
# Oversampled Data Phase Tracker

This block recovers one bit per bit period from a serial line that reaches the chip with skew and jitter. The sampling hardware in front of it captures each bit period at eight evenly spaced phases, 45 degrees apart, at a nominal rate of 133 MHz. It hands those eight samples over as one word with a valid strobe. Bit 0 of the word is the earliest sample. The block finds the data transition among the samples, keeps the sample that lies half a bit period away from it, and sends that sample out as the recovered bit.

The transition position also serves as a phase detector. The block converts its distance from the target position into a signed error and sums it in a low-pass accumulator. When the sum reaches a threshold, the block sends a one-cycle increment or decrement pulse to an external variable phase shifter, then waits a minimum number of words so the shifter can settle.

While training is enabled, the recovered bits are compared with a known rotating pattern. A lock flag rises after a long enough run of matching bits.

Top module: `oversample_phase_tracker`

## Requirements
- R1: While reset is asserted and after it is released, all five outputs are 0. The accumulator is 0, the selected sample index is 4, the match count is 0, and the settle window counts as already elapsed, so the first threshold crossing produces a pulse at once.
- R2: A transition at index i means sample i differs from sample i-1. For index 0 the comparison is with sample 7 of the previous valid word, which reset sets to 0. When a word has several transitions, the lowest index is used.
- R3: One cycle after a valid word, bit_valid is 1 and bit_out equals the sample at the selected index. On a transition, the selected index becomes (transition index + 4) mod 8. A word with no transition keeps the previous index. bit_out holds its value between valid words.
- R4: A word with a transition at index i adds a signed error of i to the accumulator for i in 0..3, and i-8 for i in 4..7. A word with no transition adds 0.
- R5: When the accumulator sum reaches +16 or more, phase_inc pulses for one cycle, one cycle after the word, and the accumulator clears. At -16 or less, phase_dec does the same. The two pulses are never high together.
- R6: At least 8 valid words lie strictly between two pulses. A crossing that is blocked by this rule clamps the accumulator to +16 or -16, and the pulse is issued on the first word for which the rule allows it.
- R7: While train_en is 1, each valid word's recovered bit is compared with train_pattern[k]. k starts at 0 and advances by one per valid word, wrapping after 31. locked rises one cycle after the 32nd consecutive match.
- R8: During training, a single mismatching bit clears both locked and the match count.
- R9: locked keeps its value while train_en is 0, and setting train_en to 0 resets k and the match count to 0. Cycles without samp_valid change no output except that bit_valid, phase_inc and phase_dec go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_valid | input | 1 | samp_word carries a new bit period |
| samp_word | input | 8 | Eight phase samples, bit 0 earliest |
| train_en | input | 1 | Compare recovered bits with the pattern |
| train_pattern | input | 32 | Rotating expected bit sequence, bit 0 first |
| bit_out | output | 1 | Recovered bit |
| bit_valid | output | 1 | bit_out updated this cycle |
| locked | output | 1 | Pattern lock achieved |
| phase_inc | output | 1 | One-cycle request to advance the phase shifter |
| phase_dec | output | 1 | One-cycle request to retard the phase shifter |

## Verification
Words with the transition at phase 0 carry random data and must give no steps. Alternating data with the transition held at phase 2 or phase 6 must give only increments or only decrements, which shows the sign of the error and its wrap. Phase 3 combined with stalls on the valid strobe raises the error faster than the settle rule allows, so the spacing between pulses becomes exactly nine words. A small set of hand-built words separates the wrap-around comparison and the lowest-index rule from their wrong variants. Training runs use 31 and 32 pattern bits, a single flipped bit, and data that mismatches while training is off.

// File: rtl/phase_track_pkg.sv
package phase_track_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/ptk_edge_locator.sv
module ptk_edge_locator #(
  parameter int NS = 8,
  localparam int IW = $clog2(NS)
) (
  input  logic [NS-1:0] word,
  input  logic          prev_last,
  output logic          found,
  output logic [IW-1:0] idx
);
  logic [NS-1:0] diff;

  generate
    for (genvar g = 0; g < NS; g++) begin : g_diff
      if (g == 0) begin : g_wrap
        assign diff[g] = word[0] ^ prev_last;
      end else begin : g_inner
        assign diff[g] = word[g] ^ word[g-1];
      end
    end
  endgenerate

  // lowest transition index wins
  always_comb begin
    found = |diff;
    idx   = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (diff[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/ptk_loop_filter.sv
module ptk_loop_filter
  import phase_track_pkg::*;
#(
  parameter int NS     = 8,
  parameter int THRESH = 16,
  parameter int SETTLE = 8,
  localparam int IW = $clog2(NS),
  localparam int AW = $clog2(THRESH) + 3,
  localparam int GW = $clog2(SETTLE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_en,
  input  logic          edge_found,
  input  logic [IW-1:0] edge_idx,
  output logic          step_up,
  output logic          step_dn
);
  localparam logic signed [AW-1:0] TH_POS = AW'(THRESH);
  localparam logic signed [AW-1:0] TH_NEG = -TH_POS;
  localparam logic signed [AW-1:0] SPAN   = AW'(NS);
  localparam logic [IW-1:0]        HALF   = IW'(NS / 2);
  localparam logic [GW-1:0]        GFULL  = GW'(SETTLE);

  logic signed [AW-1:0] acc_q, acc_d, err, sum;
  logic [GW-1:0]        gap_q, gap_d;
  step_e                step_d;
  logic                 up_q, dn_q;
  logic                 settled;

  always_comb begin
    err = '0;
    if (edge_found) begin
      err = $signed({{(AW-IW){1'b0}}, edge_idx});
      if (edge_idx >= HALF) err = err - SPAN;
    end
    sum     = acc_q + err;
    settled = (gap_q == GFULL);
  end

  always_comb begin
    acc_d  = acc_q;
    gap_d  = gap_q;
    step_d = STEP_NONE;
    if (word_en) begin
      acc_d = sum;
      if (!settled) gap_d = gap_q + GW'(1);
      if (sum >= TH_POS) begin
        if (settled) begin
          step_d = STEP_UP;
          acc_d  = '0;
          gap_d  = '0;
        end else begin
          acc_d = TH_POS;
        end
      end else if (sum <= TH_NEG) begin
        if (settled) begin
          step_d = STEP_DOWN;
          acc_d  = '0;
          gap_d  = '0;
        end else begin
          acc_d = TH_NEG;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      gap_q <= GFULL;
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
    end else begin
      acc_q <= acc_d;
      gap_q <= gap_d;
      up_q  <= (step_d == STEP_UP);
      dn_q  <= (step_d == STEP_DOWN);
    end
  end

  assign step_up = up_q;
  assign step_dn = dn_q;
endmodule

// File: rtl/ptk_pattern_lock.sv
module ptk_pattern_lock #(
  parameter int PW    = 32,
  parameter int LOCKN = 32,
  localparam int PIW = $clog2(PW),
  localparam int CW  = $clog2(LOCKN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_en,
  input  logic          train_en,
  input  logic          rx_bit,
  input  logic [PW-1:0] pattern,
  output logic          locked
);
  localparam logic [PIW-1:0] PLAST = PIW'(PW - 1);
  localparam logic [CW-1:0]  CFULL = CW'(LOCKN);

  logic [PIW-1:0] ptr_q, ptr_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           lock_q, lock_d;

  always_comb begin
    ptr_d  = ptr_q;
    cnt_d  = cnt_q;
    lock_d = lock_q;
    if (!train_en) begin
      ptr_d = '0;
      cnt_d = '0;
    end else if (word_en) begin
      ptr_d = (ptr_q == PLAST) ? '0 : ptr_q + PIW'(1);
      if (rx_bit == pattern[ptr_q]) begin
        if (cnt_q != CFULL) cnt_d = cnt_q + CW'(1);
        if (cnt_q >= CFULL - CW'(1)) lock_d = 1'b1;
      end else begin
        cnt_d  = '0;
        lock_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  assign locked = lock_q;
endmodule

// File: rtl/oversample_phase_tracker.sv
module oversample_phase_tracker #(
  parameter int NSAMP        = 8,
  parameter int STEP_THRESH  = 16,
  parameter int SETTLE_WORDS = 8,
  parameter int PAT_LEN      = 32,
  parameter int LOCK_RUN     = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               samp_valid,
  input  logic [NSAMP-1:0]   samp_word,
  input  logic               train_en,
  input  logic [PAT_LEN-1:0] train_pattern,
  output logic               bit_out,
  output logic               bit_valid,
  output logic               locked,
  output logic               phase_inc,
  output logic               phase_dec
);
  // NSAMP is a power of two so the index sum wraps naturally
  localparam int IW = $clog2(NSAMP);
  localparam logic [IW-1:0] HALF = IW'(NSAMP / 2);

  logic          prev_last_q, prev_last_d;
  logic [IW-1:0] sel_q, sel_d;
  logic          bit_q, bit_d;
  logic          bv_q;
  logic          edge_found;
  logic [IW-1:0] edge_idx;
  logic          rx_bit;

  ptk_edge_locator #(.NS(NSAMP)) u_edges (
    .word      (samp_word),
    .prev_last (prev_last_q),
    .found     (edge_found),
    .idx       (edge_idx)
  );

  always_comb begin
    sel_d       = sel_q;
    prev_last_d = prev_last_q;
    if (samp_valid) begin
      if (edge_found) sel_d = edge_idx + HALF;
      prev_last_d = samp_word[NSAMP-1];
    end
    rx_bit = samp_word[sel_d];
    bit_d  = samp_valid ? rx_bit : bit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_last_q <= 1'b0;
      sel_q       <= HALF;
      bit_q       <= 1'b0;
      bv_q        <= 1'b0;
    end else begin
      prev_last_q <= prev_last_d;
      sel_q       <= sel_d;
      bit_q       <= bit_d;
      bv_q        <= samp_valid;
    end
  end

  ptk_loop_filter #(
    .NS     (NSAMP),
    .THRESH (STEP_THRESH),
    .SETTLE (SETTLE_WORDS)
  ) u_filter (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_en    (samp_valid),
    .edge_found (edge_found),
    .edge_idx   (edge_idx),
    .step_up    (phase_inc),
    .step_dn    (phase_dec)
  );

  ptk_pattern_lock #(
    .PW    (PAT_LEN),
    .LOCKN (LOCK_RUN)
  ) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_en  (samp_valid),
    .train_en (train_en),
    .rx_bit   (rx_bit),
    .pattern  (train_pattern),
    .locked   (locked)
  );

  assign bit_out   = bit_q;
  assign bit_valid = bv_q;
endmodule

// File: rtl/ptk_checker.sv
module ptk_checker #(
  parameter int SETTLE_WORDS = 8
) (
  input logic clk,
  input logic rst_n,
  input logic samp_valid,
  input logic train_en,
  input logic bit_valid,
  input logic locked,
  input logic phase_inc,
  input logic phase_dec
);
  logic       seen_q;
  logic [7:0] words_q;
  logic       pulse;

  assign pulse = phase_inc | phase_dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      words_q <= '0;
    end else if (pulse) begin
      seen_q  <= 1'b1;
      words_q <= {7'd0, samp_valid};
    end else if (samp_valid && words_q != 8'hFF) begin
      words_q <= words_q + 8'd1;
    end
  end

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(phase_inc && phase_dec)); // R5
  AST_STEP_FROM_WORD: assert property (@(posedge clk) disable iff (!rst_n) pulse |-> $past(samp_valid)); // R5
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) pulse |=> !pulse); // R6
  AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n) (pulse && seen_q) |-> (32'(words_q) > SETTLE_WORDS)); // R6
  AST_BIT_FROM_WORD: assert property (@(posedge clk) disable iff (!rst_n) bit_valid |-> $past(samp_valid)); // R3
  AST_LOCK_NEEDS_TRAIN: assert property (@(posedge clk) disable iff (!rst_n) $rose(locked) |-> $past(train_en)); // R7
  AST_IDLE_LOCK_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !samp_valid |=> $stable(locked)); // R9
endmodule

bind oversample_phase_tracker ptk_checker #(.SETTLE_WORDS(SETTLE_WORDS)) u_ptk_chk (.*);

// File: tb/tb_oversample_phase_tracker.sv
module tb_oversample_phase_tracker;
  localparam int TH = 16;
  localparam int SET = 8;
  localparam int RUN = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        samp_valid = 1'b0;
  logic [7:0]  samp_word = '0;
  logic        train_en = 1'b0;
  logic [31:0] train_pattern = 32'hA5C3_96E1;
  logic        bit_out, bit_valid, locked, phase_inc, phase_dec;

  oversample_phase_tracker dut (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_word(samp_word),
    .train_en(train_en), .train_pattern(train_pattern), .bit_out(bit_out),
    .bit_valid(bit_valid), .locked(locked), .phase_inc(phase_inc), .phase_dec(phase_dec)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // behavioural reference model
  int m_prev, m_sel, m_acc, m_gap, m_ptr, m_cnt;
  bit m_locked, m_bit, m_bv, m_inc, m_dec;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = 0; m_sel = 4; m_acc = 0; m_gap = SET; m_ptr = 0; m_cnt = 0;
      m_locked = 0; m_bit = 0; m_bv = 0; m_inc = 0; m_dec = 0;
    end else begin
      int e, err;
      m_bv = samp_valid; m_inc = 0; m_dec = 0;
      if (!train_en) begin m_ptr = 0; m_cnt = 0; end
      if (samp_valid) begin
        e = -1;
        for (int i = 7; i >= 0; i--) begin
          if (samp_word[i] != ((i == 0) ? m_prev[0] : samp_word[i-1])) e = i;
        end
        err = 0;
        if (e >= 0) begin m_sel = (e + 4) % 8; err = (e < 4) ? e : e - 8; end
        m_bit = samp_word[m_sel];
        m_prev = samp_word[7];
        m_acc += err;
        if (m_acc >= TH) begin
          if (m_gap >= SET) begin m_inc = 1; m_acc = 0; m_gap = 0; end
          else begin m_acc = TH; m_gap++; end
        end else if (m_acc <= -TH) begin
          if (m_gap >= SET) begin m_dec = 1; m_acc = 0; m_gap = 0; end
          else begin m_acc = -TH; m_gap++; end
        end else if (m_gap < SET) m_gap++;
        if (train_en) begin
          if (m_bit == train_pattern[m_ptr]) begin
            if (m_cnt < RUN) m_cnt++;
            if (m_cnt >= RUN) m_locked = 1;
          end else begin m_cnt = 0; m_locked = 0; end
          m_ptr = (m_ptr + 1) % 32;
        end
      end
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    check("R3 bit_valid model", int'(bit_valid), int'(m_bv));
    check("R3 bit_out model", int'(bit_out), int'(m_bit));
    check("R7 locked model", int'(locked), int'(m_locked));
    check("R5 phase_inc model", int'(phase_inc), int'(m_inc));
    check("R5 phase_dec model", int'(phase_dec), int'(m_dec));
  end

  // pulse statistics per segment
  int inc_cnt = 0, dec_cnt = 0, wcnt = 0, min_gap = 1000;
  bit seen_pulse = 0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (phase_inc || phase_dec) begin
        if (phase_inc) inc_cnt++;
        if (phase_dec) dec_cnt++;
        if (seen_pulse && wcnt < min_gap) min_gap = wcnt;
        seen_pulse = 1;
        wcnt = samp_valid ? 1 : 0;
      end else if (samp_valid) wcnt++;
    end
  end

  task automatic clear_stats();
    inc_cnt = 0; dec_cnt = 0; min_gap = 1000; seen_pulse = 0; wcnt = 0;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  bit prev_bit = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic next_lfsr_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic send_raw(input logic [7:0] w);
    samp_word = w; samp_valid = 1;
    @(negedge clk);
    samp_valid = 0;
  endtask

  task automatic send_bit(input bit cur, input int e, input bit stall);
    logic [7:0] w;
    for (int i = 0; i < 8; i++) w[i] = (i < e) ? prev_bit : cur;
    send_raw(w);
    prev_bit = cur;
    if (stall) @(negedge clk);
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 bit_valid in reset", int'(bit_valid), 0);
    check("R1 locked in reset", int'(locked), 0);
    check("R1 pulses in reset", int'(phase_inc | phase_dec), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 bit_out after release", int'(bit_out), 0);

    // R5/R1: phase 2 alternating, first pulse after exactly 8 words
    clear_stats();
    for (int n = 0; n < 7; n++) send_bit(~prev_bit, 2, 0);
    check("R5 no inc before 8 words", int'(phase_inc), 0);
    send_bit(~prev_bit, 2, 0);
    check("R5 inc after sum reaches +16", int'(phase_inc), 1);
    @(negedge clk);
    check("R5 inc is one cycle", int'(phase_inc), 0);
    for (int n = 0; n < 20; n++) send_bit(~prev_bit, 2, 0);
    check("R4 phase 2 gives no dec", dec_cnt, 0);

    // R4: phase 6 gives decrements only
    clear_stats();
    for (int n = 0; n < 30; n++) send_bit(~prev_bit, 6, n % 4 == 0);
    check("R4 phase 6 gives dec", int'(dec_cnt >= 2), 1);
    check("R4 phase 6 gives no inc", inc_cnt, 0);

    // R4: phase 0 random data, no steps
    clear_stats();
    for (int n = 0; n < 40; n++) send_bit(next_lfsr_bit(), 0, 0);
    check("R4 phase 0 no steps", inc_cnt + dec_cnt, 0);

    // R6: phase 3 with stalls, pulses spaced exactly 9 words
    clear_stats();
    for (int n = 0; n < 60; n++) send_bit(~prev_bit, 3, n % 3 == 1);
    check("R6 spacing between pulses", min_gap, 9);
    check("R6 several pulses", int'(inc_cnt >= 3), 1);

    // R2 wrap-around comparison with previous sample 7
    send_raw(8'hFF);
    send_raw(8'h1E);
    check("R2 wrap transition at index 0", int'(bit_out), 1);
    // R2 lowest index wins
    send_raw(8'h00);
    send_raw(8'h0F);
    check("R2 lowest transition index", int'(bit_out), 0);
    // R3 selection from transition, then hold without transitions
    send_raw(8'h00);
    send_raw(8'hFC);
    check("R3 sample at index 6", int'(bit_out), 1);
    clear_stats();
    repeat (5) @(negedge clk);
    check("R9 idle keeps bit_out", int'(bit_out), 1);
    check("R9 idle bit_valid low", int'(bit_valid), 0);
    for (int n = 0; n < 20; n++) send_raw(8'hFF);
    check("R3 held selection output", int'(bit_out), 1);
    check("R4 no transition no step", inc_cnt + dec_cnt, 0);
    prev_bit = 1;

    // R7 training: 31 matches not enough, 32 locks
    for (int n = 0; n < 4; n++) send_bit(next_lfsr_bit(), 1, 0);
    train_en = 1;
    for (int n = 0; n < 31; n++) send_bit(train_pattern[n], 1, n == 10);
    check("R7 not locked after 31", int'(locked), 0);
    send_bit(train_pattern[31], 1, 0);
    check("R7 locked after 32", int'(locked), 1);
    // R8 one mismatch clears lock
    send_bit(~train_pattern[0], 1, 0);
    check("R8 mismatch clears lock", int'(locked), 0);
    // relock from a fresh start
    train_en = 0;
    @(negedge clk);
    train_en = 1;
    for (int n = 0; n < 32; n++) send_bit(train_pattern[n], 1, 0);
    check("R7 relock after restart", int'(locked), 1);
    // R9 lock held while training is off
    train_en = 0;
    for (int n = 0; n < 10; n++) send_bit(~train_pattern[n], 1, 0);
    check("R9 lock held with training off", int'(locked), 1);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule